// File: doc/BRIEF.md
# SDRAM Row Activation Timing Gate

This block sits between an SDRAM command source and the memory command bus. It checks each proposed command before it reaches the memory. For every bank it records whether a row is open and which row that is. It keeps down-counters for the open-to-access delay and the same-bank activate-to-activate delay in each bank, plus one device-wide counter for activate-to-activate spacing between banks. The timing limits are given in nanoseconds along with the clock period. At elaboration each limit becomes a cycle count: the limit is divided by the period and the result is rounded up.

The command source presents a valid command with an opcode, a bank and a row. The gate answers in the same cycle with `cmd_ready` and `cmd_illegal`. `cmd_ready` is high when every timing counter that applies to the command has run out. `cmd_illegal` is high when the command breaks a bank-state rule. A command is accepted and forwarded on the `mem_*` outputs only when it is valid, ready and legal. A valid illegal command is dropped, and it sets a sticky error flag.

Top module: `sdram_act_gate`

## Requirements
- R1: After a synchronous active-low reset, all banks are closed, all timing counters are zero and `err_sticky` is 0. An ACTIVE to any bank is then ready and legal, and a READ to any bank is illegal.
- R2: Each nanosecond limit becomes ceil(limit / period) cycles. With the defaults of 8 ns period, 20 ns open-to-access, 60 ns same-bank activate spacing and 15 ns cross-bank activate spacing, the counts are 3, 8 and 2 cycles.
- R3: A READ (opcode 2) or WRITE (opcode 3) to a closed bank raises `cmd_illegal`, is not forwarded, and sets `err_sticky` on the next clock edge.
- R4: Take an ACTIVE accepted at clock edge E. A READ or WRITE to the same bank has `cmd_ready` low before edge E+TRCD and high from edge E+TRCD onward.
- R5: An ACTIVE (opcode 1) to a bank that already holds an open row is illegal, whatever row it names. This stays true until a PRECHARGE to that bank is accepted.
- R6: Take an ACTIVE to a bank accepted at edge E. A later ACTIVE to the same bank is not ready before edge E+TRC.
- R7: Take an ACTIVE accepted at edge E. An ACTIVE to any other bank is not ready before edge E+TRRD. Accesses to a bank that is already open and past its open-to-access delay stay ready while other banks are being activated.
- R8: A forwarded READ or WRITE carries on `mem_row` the row that was latched by the ACTIVE that opened that bank.
- R9: A PRECHARGE (opcode 4) is always ready and legal. On a closed bank it is legal too. Once accepted it closes the bank, so a later ACTIVE to that bank is legal.
- R10: `err_sticky` stays set once it is set, and only reset clears it.
- R11: A NOP (opcode 0) is ready and legal and is never forwarded (`mem_valid` stays 0). Opcodes 5 to 7 are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Proposed command is present |
| cmd_op | input | 3 | Opcode: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 13 | Row address (used by ACTIVE) |
| cmd_ready | output | 1 | All timing counters for this command have expired |
| cmd_illegal | output | 1 | Command breaks a bank-state rule |
| err_sticky | output | 1 | A valid illegal command has been seen since reset |
| mem_valid | output | 1 | Accepted command is on the memory bus |
| mem_op | output | 3 | Forwarded opcode |
| mem_bank | output | 2 | Forwarded bank |
| mem_row | output | 13 | Forwarded row (the open row for READ/WRITE) |

## Verification
The bench holds a READ, or a repeated ACTIVE, on the inputs and counts how many edges pass before `cmd_ready` first rises. It compares that count with the round-up of the nanosecond limits. A counter loaded with the full count instead of count minus one, or a truncating conversion, would move the count by one edge. An ACTIVE to an open bank with a different row is tried; a design that only compared rows would forward it. A cross-bank ACTIVE is timed against the global spacing, and a READ to a third, ready bank is checked for staying ready. Rows latched by ACTIVE are read back on `mem_row`, so a bank mix-up in the row store would show as a wrong row.

// File: rtl/sdram_gate_pkg.sv
// Package for the activation gate: the opcode encoding and the
// conversion of a nanosecond limit into a whole number of clock cycles.
// Assumes all limits and the clock period are positive integers in ns.
package sdram_gate_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } sd_op_e;

    // Round-up division of a limit by the clock period.
    function automatic int ns_to_cyc(input int lim_ns, input int tck_ns);
        return (lim_ns + tck_ns - 1) / tck_ns;
    endfunction

endpackage

// File: rtl/gate_down_cnt.sv
// Reloadable down-counter. A load sets it to load_val. After that it
// drops by one each clock until it reaches zero. zero is high at zero.
// Assumes load_val fits in WIDTH bits.
module gate_down_cnt #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);
    logic [WIDTH-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R4: a nonzero load must keep the counter busy for at least one cycle
    cnt_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/gate_bank_slot.sv
// State of one bank: the open flag, the latched row, and the
// open-to-access and same-bank activate-spacing counters.
// Assumes act_go and pre_go are never high together.
module gate_bank_slot #(
    parameter int ROW_W  = 13,
    parameter int CNT_W  = 4,
    parameter int RCD_LD = 2,
    parameter int RC_LD  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rcd_zero,
    output logic             rc_zero
);
    // Open flag: set by an accepted ACTIVE, cleared by an accepted PRECHARGE.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_open <= 1'b0;
        else if (act_go)
            is_open <= 1'b1;
        else if (pre_go)
            is_open <= 1'b0;
    end

    // Row store: capture the row named by the accepted ACTIVE.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_row <= '0;
        else if (act_go)
            open_row <= row_in;
    end

    gate_down_cnt #(.WIDTH(CNT_W)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load(act_go),
        .load_val(CNT_W'(RCD_LD)), .zero(rcd_zero)
    );

    gate_down_cnt #(.WIDTH(CNT_W)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(act_go),
        .load_val(CNT_W'(RC_LD)), .zero(rc_zero)
    );

    // R5: an ACTIVE is only accepted while the bank is closed
    act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> !is_open);
endmodule

// File: rtl/gate_rule_check.sv
// Combinational rule check for the command on offer. ready is high
// when every timing counter for the command has expired. illegal is
// high when the command breaks a bank-state rule.
// Assumes bank indexes a populated bank.
module gate_rule_check
    import sdram_gate_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  sd_op_e               op,
    input  logic [BANK_W-1:0]    bank,
    input  logic [NUM_BANKS-1:0] open_vec,
    input  logic [NUM_BANKS-1:0] rcd_zero_vec,
    input  logic [NUM_BANKS-1:0] rc_zero_vec,
    input  logic                 rrd_zero,
    output logic                 ready,
    output logic                 illegal
);
    // Decode the per-opcode timing and state conditions.
    always_comb begin
        ready   = 1'b1;
        illegal = 1'b0;
        case (op)
            OP_NOP: ;
            OP_ACT: begin
                ready   = rc_zero_vec[bank] && rrd_zero;
                illegal = open_vec[bank];
            end
            OP_RD, OP_WR: begin
                ready   = rcd_zero_vec[bank];
                illegal = !open_vec[bank];
            end
            OP_PRE: ;
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdram_act_gate.sv
// SDRAM row activation timing gate (top). It converts the nanosecond
// limits to cycles, keeps one slot per bank and a global cross-bank
// activate counter, and forwards each command that is valid, ready and
// legal. Illegal commands are dropped and set a sticky flag.
// Assumes NUM_BANKS is a power of two and all timing limits are positive.
module sdram_act_gate
    import sdram_gate_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int TCK_NS    = 8,
    parameter int TRCD_NS   = 20,
    parameter int TRC_NS    = 60,
    parameter int TRRD_NS   = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic [ROW_W-1:0]             cmd_row,
    output logic                         cmd_ready,
    output logic                         cmd_illegal,
    output logic                         err_sticky,
    output logic                         mem_valid,
    output logic [2:0]                   mem_op,
    output logic [$clog2(NUM_BANKS)-1:0] mem_bank,
    output logic [ROW_W-1:0]             mem_row
);
    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int RCD_CYC = ns_to_cyc(TRCD_NS, TCK_NS);
    localparam int RC_CYC  = ns_to_cyc(TRC_NS, TCK_NS);
    localparam int RRD_CYC = ns_to_cyc(TRRD_NS, TCK_NS);
    localparam int MAX_CYC = (RC_CYC > RCD_CYC) ? ((RC_CYC > RRD_CYC) ? RC_CYC : RRD_CYC)
                                                : ((RCD_CYC > RRD_CYC) ? RCD_CYC : RRD_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int RCD_LD  = RCD_CYC - 1;
    localparam int RC_LD   = RC_CYC - 1;
    localparam int RRD_LD  = RRD_CYC - 1;

    sd_op_e               op;
    logic                 accept;
    logic                 rrd_zero;
    logic [NUM_BANKS-1:0] open_vec, rcd_zero_vec, rc_zero_vec;
    logic [ROW_W-1:0]     open_row [NUM_BANKS];

    assign op     = sd_op_e'(cmd_op);
    assign accept = cmd_valid && cmd_ready && !cmd_illegal;

    // One state slot per bank, each driven by its own decoded strobes.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic act_go, pre_go;
        assign act_go = accept && (op == OP_ACT) && (cmd_bank == BANK_W'(b));
        assign pre_go = accept && (op == OP_PRE) && (cmd_bank == BANK_W'(b));

        gate_bank_slot #(
            .ROW_W(ROW_W), .CNT_W(CNT_W), .RCD_LD(RCD_LD), .RC_LD(RC_LD)
        ) u_slot (
            .clk(clk), .rst_n(rst_n), .act_go(act_go), .pre_go(pre_go),
            .row_in(cmd_row), .is_open(open_vec[b]), .open_row(open_row[b]),
            .rcd_zero(rcd_zero_vec[b]), .rc_zero(rc_zero_vec[b])
        );
    end

    gate_down_cnt #(.WIDTH(CNT_W)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(accept && op == OP_ACT),
        .load_val(CNT_W'(RRD_LD)), .zero(rrd_zero)
    );

    gate_rule_check #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_rules (
        .op(op), .bank(cmd_bank), .open_vec(open_vec),
        .rcd_zero_vec(rcd_zero_vec), .rc_zero_vec(rc_zero_vec),
        .rrd_zero(rrd_zero), .ready(cmd_ready), .illegal(cmd_illegal)
    );

    // Sticky error: set by any offered command that breaks a state rule.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_sticky <= 1'b0;
        else if (cmd_valid && cmd_illegal)
            err_sticky <= 1'b1;
    end

    // Forwarding: non-NOP accepted commands, with the open row for accesses.
    always_comb begin
        mem_valid = accept && (op != OP_NOP);
        mem_op    = cmd_op;
        mem_bank  = cmd_bank;
        mem_row   = (op == OP_RD || op == OP_WR) ? open_row[cmd_bank] : cmd_row;
    end

    // R3
    acc_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && (op == OP_RD || op == OP_WR)) |-> open_vec[cmd_bank]);
    // R4
    acc_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && (op == OP_RD || op == OP_WR)) |-> rcd_zero_vec[cmd_bank]);
    // R7
    act_rrd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && op == OP_ACT) |-> rrd_zero);
    // R6
    act_rc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && op == OP_ACT) |-> rc_zero_vec[cmd_bank]);
    // R5
    act_opens_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_ACT) |=> open_vec[$past(cmd_bank)]);
    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
    // R3
    illegal_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |-> !mem_valid);
endmodule

// File: tb/sim_sdram_act_gate.sv
module sim_sdram_act_gate;
    localparam int TCK = 8, TRCD = 20, TRC = 60, TRRD = 15;
    localparam int E_RCD = (TRCD + TCK - 1) / TCK;
    localparam int E_RC  = (TRC  + TCK - 1) / TCK;
    localparam int E_RRD = (TRRD + TCK - 1) / TCK;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [12:0] cmd_row = 13'd0;
    logic cmd_ready, cmd_illegal, err_sticky, mem_valid;
    logic [2:0] mem_op;
    logic [1:0] mem_bank;
    logic [12:0] mem_row;

    int checks = 0, fails = 0, cyc = 0;
    logic r_rdy, r_ill, r_mv;
    logic [12:0] r_row;

    always #2 clk = ~clk;

    sdram_act_gate u0 (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Present one command for one edge; sample the combinational answers.
    task automatic issue(input logic [2:0] op, input logic [1:0] b, input logic [12:0] row);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = b; cmd_row = row;
        #1 r_rdy = cmd_ready; r_ill = cmd_illegal; r_mv = mem_valid; r_row = mem_row;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Hold a command until ready; return the 1-based edge count.
    task automatic measure(input logic [2:0] op, input logic [1:0] b, input logic [12:0] row,
                           output int k);
        k = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = b; cmd_row = row;
        for (int i = 1; i <= 40; i++) begin
            #1;
            if (cmd_ready) begin
                k = i; r_row = mem_row; r_ill = cmd_illegal;
                @(posedge clk); @(negedge clk);
                break;
            end
            @(posedge clk); @(negedge clk);
        end
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_bank = 2'd2; #1;
        chk("R1 act ready", cmd_ready, 1); chk("R1 act legal", cmd_illegal, 0);
        cmd_op = 3'd2; #1;
        chk("R1 read illegal", cmd_illegal, 1);
        chk("R1 err clear", err_sticky, 0);
        cmd_valid = 1'b0;
    endtask

    task automatic t_closed_access();
        do_reset();
        issue(3'd2, 2'd1, 13'd0);
        chk("R3 read closed illegal", r_ill, 1); chk("R3 not forwarded", r_mv, 0);
        chk("R3 err set", err_sticky, 1);
        issue(3'd0, 2'd0, 13'd0);
        issue(3'd1, 2'd0, 13'd5);
        chk("R10 err holds", err_sticky, 1);
        issue(3'd3, 2'd3, 13'd0);
        chk("R3 write closed illegal", r_ill, 1);
    endtask

    task automatic t_rcd_row();
        int k;
        do_reset();
        issue(3'd1, 2'd0, 13'h1abc);
        chk("R1 first act forwarded", r_mv, 1);
        measure(3'd2, 2'd0, 13'd0, k);
        chk("R4 R2 rcd edges", k, E_RCD);
        chk("R8 read row", r_row, 13'h1abc);
        issue(3'd3, 2'd0, 13'd7);
        chk("R8 write row", r_row, 13'h1abc);
        chk("R4 write ready", r_rdy, 1);
    endtask

    task automatic t_rc_pre();
        int k;
        do_reset();
        issue(3'd1, 2'd2, 13'd33);            // edge E0
        measure(3'd2, 2'd2, 13'd0, k);        // accepted at E3
        issue(3'd4, 2'd2, 13'd0);             // precharge at E4
        chk("R9 pre ready", r_rdy, 1); chk("R9 pre legal", r_ill, 0);
        measure(3'd1, 2'd2, 13'd44, k);       // k=1 means E5
        chk("R6 R2 rc edges", k + 4, E_RC);
        chk("R9 act after pre legal", r_ill, 0);
        issue(3'd4, 2'd3, 13'd0);
        chk("R9 pre on closed legal", r_ill, 0);
    endtask

    task automatic t_open_act();
        do_reset();
        issue(3'd1, 2'd1, 13'd10);
        repeat (E_RC + 1) @(negedge clk);
        issue(3'd1, 2'd1, 13'd11);
        chk("R5 act open illegal", r_ill, 1); chk("R5 not forwarded", r_mv, 0);
        issue(3'd1, 2'd1, 13'd10);
        chk("R5 same row illegal", r_ill, 1);
    endtask

    task automatic t_rrd();
        int k;
        do_reset();
        issue(3'd1, 2'd0, 13'd1);             // E0
        measure(3'd1, 2'd3, 13'd2, k);
        chk("R7 R2 rrd edges", k, E_RRD);
        issue(3'd1, 2'd1, 13'd3);             // bank0 rcd done here
        issue(3'd2, 2'd0, 13'd0);
        chk("R7 open bank ready during acts", r_rdy, 1);
        chk("R8 bank0 row kept", r_row, 13'd1);
    endtask

    task automatic t_nop_bad();
        do_reset();
        issue(3'd0, 2'd0, 13'd0);
        chk("R11 nop ready", r_rdy, 1); chk("R11 nop legal", r_ill, 0);
        chk("R11 nop not forwarded", r_mv, 0);
        issue(3'd6, 2'd0, 13'd0);
        chk("R11 bad op illegal", r_ill, 1);
    endtask

    initial begin
        t_reset();
        t_closed_access();
        t_rcd_row();
        t_rc_pre();
        t_open_act();
        t_rrd();
        t_nop_bad();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule